// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the software-visible configuration of a bank of general-purpose I/O pads. It decodes a simple synchronous register bus and stores two kinds of state. Bitmap words keep one bit per pin, packed 32 pins to a word. Per-pin word pairs hold each pad's function select, direction, output level, trigger flavour, input-sense disable and weak-pull setting. The stored state drives the pad controls directly. It also exports trigger type, trigger polarity, ownership-qualified interrupt enables and routing flags to a separate interrupt detector.

Pad input levels pass through a two-stage synchroniser and are shown in a read-only bit of each pin's first word. When a pin's input sensing is off, that level reads zero and is not forwarded to the interrupt logic. Pins that firmware has kept for itself (ownership bit clear) can never become interrupt sources. The pin count is a parameter (default 95, at most 128). Offsets that hold no register read as zero and ignore writes.

Top module: `gpio_pad_regbank`

## Requirements
- R1: After reset every pin's first word reads 0x0000_0005 (GPIO use, input, sampled level 0 with pads low), every second word reads 0, and every bitmap, the routing word and the global control word read 0.
- R2: A read issued with re_i in one cycle presents the addressed word on rdata_o in the next cycle, and rdata_o holds its value in cycles without a read.
- R3: The ownership bitmap (offset 0x00) and the enable bitmap (offset 0x90) are read/write at base + (pin/32)*4, bit pin%32, and bits for pins at or above the pin count read 0.
- R4: The first word of pin p sits at 0x100 + p*8. It holds output level at bit 31, the read-only sampled input at bit 30, level trigger at bit 4 (0 edge), trigger invert at bit 3, direction at bit 2 (1 input), use select at bits 1:0 (1 GPIO, 0 native). Other bits read 0, and trig_level_o/trig_inv_o follow bits 4 and 3.
- R5: The second word of pin p sits at 0x104 + p*8. Bit 2 disables input sensing, and bits 1:0 select the weak pull (0 none, 1 down, 2 up), driven on pad_pull_o[2p+1:2p].
- R6: pad_oe_o[p] is high only when use select is 1 and direction is 0, and pad_out_o[p] follows bit 31 of the first word.
- R7: pad_in_i reaches bit 30 and sense_o after two clock edges. While input sensing is disabled, pad_ie_o is low and both bit 30 and sense_o read 0.
- R8: The routing word at 0x10 keeps bits 15:0 (bits 31:16 and words 0x14, 0x18 read 0). Bits 0–2 route pins 8–10, bits 3–4 pins 13–14 and bits 5–15 pins 45–55 on route_o, and every other pin reads as not routed.
- R9: The status bitmap at 0x80 latches irq_event_i only for owned pins. Writing 1 to a bit clears it, and an event in the same cycle wins over the clear.
- R10: int_en_o[p] is high only when both the enable bit and the ownership bit of pin p are set.
- R11: Bit 0 of the global control word at 0x7C is read/write and drives irq_line_sel_o. Its other bits read 0.
- R12: Reads of unimplemented offsets, of bitmap word indices at or above ceil(pins/32), and of pins at or above the pin count return 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| pad_in_i | input | NUM_PINS | Asynchronous pad input levels |
| pad_out_o | output | NUM_PINS | Pad output levels |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| pad_ie_o | output | NUM_PINS | Pad input-sense enables |
| pad_pull_o | output | 2*NUM_PINS | Weak-pull select, two bits per pin |
| sense_o | output | NUM_PINS | Synchronised, sense-gated input levels for interrupt logic |
| trig_level_o | output | NUM_PINS | Trigger type per pin (1 level, 0 edge) |
| trig_inv_o | output | NUM_PINS | Trigger polarity invert per pin |
| route_o | output | NUM_PINS | Interrupt routing flag per pin |
| int_en_o | output | NUM_PINS | Ownership-qualified interrupt enable per pin |
| irq_event_i | input | NUM_PINS | Detected interrupt events from the detector |
| irq_line_sel_o | output | 1 | Global interrupt line select |

## Verification
A corrupted field in a pin's stored configuration shows at the pad controls on the clock after the write that set it, and it shows on rdata_o one cycle after any read of that word. Decode faults that alias pins, words or bitmap groups show up as a wrong word on the next read or as a wrong pad, routing or enable bit. A cycle-by-cycle reference model therefore compares every output on every clock. A status or synchroniser fault shows within one to two cycles of the event or pad change that exercises it.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  localparam logic [3:0] GRP_OWN   = 4'h0;
  localparam logic [3:0] GRP_ROUTE = 4'h1;
  localparam logic [3:0] GRP_GCTL  = 4'h7;
  localparam logic [3:0] GRP_STAT  = 4'h8;
  localparam logic [3:0] GRP_EN    = 4'h9;
  localparam logic [1:0] GCTL_WIDX = 2'd3;

  localparam int unsigned PIN_BASE = 32'h100;
  localparam int unsigned ROUTE_W  = 16;
  localparam logic [1:0]  USE_GPIO = 2'b01;

  typedef struct packed {
    logic       out_lvl;
    logic       trig_lvl;
    logic       trig_inv;
    logic       dir_in;
    logic [1:0] use_sel;
    logic       sense_off;
    logic [1:0] pull;
  } pin_cfg_t;

  localparam pin_cfg_t PIN_CFG_RST = '{
    out_lvl:   1'b0,
    trig_lvl:  1'b0,
    trig_inv:  1'b0,
    dir_in:    1'b1,
    use_sel:   USE_GPIO,
    sense_off: 1'b0,
    pull:      2'b00
  };

  // routing-word bit that serves a pin, -1 when the pin has none
  function automatic int route_slot(int pin);
    if (pin >= 8  && pin <= 10) return pin - 8;
    if (pin >= 13 && pin <= 14) return pin - 10;
    if (pin >= 45 && pin <= 55) return pin - 40;
    return -1;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_regbank_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_c1_i,
  input  logic        wr_c2_i,
  input  logic [31:0] wdata_i,
  output pin_cfg_t    cfg_o,
  output logic        oe_o
);

  pin_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= PIN_CFG_RST;
    end else begin
      if (wr_c1_i) begin
        cfg_q.out_lvl  <= wdata_i[31];
        cfg_q.trig_lvl <= wdata_i[4];
        cfg_q.trig_inv <= wdata_i[3];
        cfg_q.dir_in   <= wdata_i[2];
        cfg_q.use_sel  <= wdata_i[1:0];
      end
      if (wr_c2_i) begin
        cfg_q.sense_off <= wdata_i[2];
        cfg_q.pull      <= wdata_i[1:0];
      end
    end
  end

  assign cfg_o = cfg_q;
  assign oe_o  = (cfg_q.use_sel == USE_GPIO) && !cfg_q.dir_in;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[30:5];

  assert_oe_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_c1_i |=> (oe_o == (($past(wdata_i[1:0]) == USE_GPIO) && !$past(wdata_i[2]))));

endmodule

// File: rtl/gpio_bitmaps.sv
module gpio_bitmaps
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 95
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [3:0]          grp_i,
  input  logic [1:0]          widx_i,
  input  logic [31:0]         wdata_i,
  input  logic [NUM_PINS-1:0] irq_event_i,
  output logic [NUM_PINS-1:0] own_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [ROUTE_W-1:0]  route_bits_o,
  output logic                gsel_o,
  output logic                hit_o,
  output logic [31:0]         rd_o
);

  localparam int unsigned NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int unsigned BM_W      = NUM_WORDS * 32;

  function automatic logic [BM_W-1:0] pin_mask();
    logic [BM_W-1:0] m;
    for (int i = 0; i < BM_W; i++) m[i] = (i < NUM_PINS);
    return m;
  endfunction

  function automatic logic [31:0] pick(logic [BM_W-1:0] vec, logic [1:0] idx);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (int'(idx) == k) w = vec[k*32 +: 32];
    return w;
  endfunction

  localparam logic [BM_W-1:0] MASK = pin_mask();

  logic [BM_W-1:0]    own_q, en_q, stat_q;
  logic [ROUTE_W-1:0] route_q;
  logic               gsel_q;
  logic [BM_W-1:0]    word_sel, wmask, wd_rep, evt_ext, clr;
  logic               word_ok, wr_own, wr_en, wr_stat, wr_route, wr_gctl;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++)
      word_sel[w*32 +: 32] = {32{int'(widx_i) == w}};
  end

  assign wd_rep   = {NUM_WORDS{wdata_i}};
  assign evt_ext  = BM_W'(irq_event_i);
  assign wmask    = word_sel & MASK;
  assign word_ok  = int'(widx_i) < NUM_WORDS;
  assign wr_own   = sel_i && we_i && grp_i == GRP_OWN  && word_ok;
  assign wr_en    = sel_i && we_i && grp_i == GRP_EN   && word_ok;
  assign wr_stat  = sel_i && we_i && grp_i == GRP_STAT && word_ok;
  assign wr_route = sel_i && we_i && grp_i == GRP_ROUTE && widx_i == 2'd0;
  assign wr_gctl  = sel_i && we_i && grp_i == GRP_GCTL  && widx_i == GCTL_WIDX;
  assign clr      = wr_stat ? (wd_rep & wmask) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= '0;
      en_q    <= '0;
      stat_q  <= '0;
      route_q <= '0;
      gsel_q  <= 1'b0;
    end else begin
      if (wr_own)   own_q   <= (own_q & ~wmask) | (wd_rep & wmask);
      if (wr_en)    en_q    <= (en_q  & ~wmask) | (wd_rep & wmask);
      if (wr_route) route_q <= wdata_i[ROUTE_W-1:0];
      if (wr_gctl)  gsel_q  <= wdata_i[0];
      // a new event wins over a same-cycle clear
      stat_q <= ((stat_q & ~clr) | (evt_ext & own_q)) & MASK;
    end
  end

  always_comb begin
    hit_o = 1'b0;
    rd_o  = '0;
    if (sel_i) begin
      unique case (grp_i)
        GRP_OWN:   begin hit_o = word_ok; rd_o = pick(own_q, widx_i);  end
        GRP_EN:    begin hit_o = word_ok; rd_o = pick(en_q, widx_i);   end
        GRP_STAT:  begin hit_o = word_ok; rd_o = pick(stat_q, widx_i); end
        GRP_ROUTE: if (widx_i == 2'd0) begin
                     hit_o = 1'b1;
                     rd_o  = {{(32-ROUTE_W){1'b0}}, route_q};
                   end
        GRP_GCTL:  if (widx_i == GCTL_WIDX) begin
                     hit_o = 1'b1;
                     rd_o  = {31'b0, gsel_q};
                   end
        default: ;
      endcase
    end
  end

  assign own_o        = own_q[NUM_PINS-1:0];
  assign en_o         = en_q[NUM_PINS-1:0];
  assign route_bits_o = route_q;
  assign gsel_o       = gsel_q;

  logic unused_stat;
  assign unused_stat = ^(stat_q & ~MASK) ^ ^(own_q & ~MASK) ^ ^(en_q & ~MASK);

  assert_route_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_route |=> route_q == $past(wdata_i[ROUTE_W-1:0]));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    assert_stat_needs_owner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_q[p]) |-> $past(own_q[p]));
    assert_stat_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stat && wmask[p] && wd_rep[p] && !(evt_ext[p] && own_q[p])) |=> !stat_q[p]);
  end

endmodule

// File: rtl/gpio_pad_regbank.sv
module gpio_pad_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 95,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  input  logic                  we_i,
  input  logic                  re_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   pad_in_i,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [NUM_PINS-1:0]   pad_ie_o,
  output logic [2*NUM_PINS-1:0] pad_pull_o,
  output logic [NUM_PINS-1:0]   sense_o,
  output logic [NUM_PINS-1:0]   trig_level_o,
  output logic [NUM_PINS-1:0]   trig_inv_o,
  output logic [NUM_PINS-1:0]   route_o,
  output logic [NUM_PINS-1:0]   int_en_o,
  input  logic [NUM_PINS-1:0]   irq_event_i,
  output logic                  irq_line_sel_o
);

  localparam int unsigned IDX_W = ADDR_W - 3;

  logic              in_pin, pin_hit, c2_sel, bm_hit;
  logic [ADDR_W-1:0] pin_off;
  logic [IDX_W-1:0]  pin_idx;
  logic [31:0]       bm_rd, pin_word, rd_word, rdata_q;

  logic [NUM_PINS-1:0] sync_lvl, sense_lvl, own, en, wr_c1, wr_c2;
  logic [ROUTE_W-1:0]  route_bits;
  pin_cfg_t            cfg [NUM_PINS];
  pin_cfg_t            sel_cfg;
  logic                sel_sense;

  assign in_pin  = |addr_i[ADDR_W-1:8];
  assign pin_off = addr_i - ADDR_W'(PIN_BASE);
  assign pin_idx = pin_off[ADDR_W-1:3];
  assign pin_hit = in_pin && (pin_idx < IDX_W'(NUM_PINS));
  assign c2_sel  = addr_i[2];

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pad_in_i),
    .sync_o (sync_lvl)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int SLOT = route_slot(p);

    assign wr_c1[p] = we_i && pin_hit && pin_idx == IDX_W'(p) && !c2_sel;
    assign wr_c2[p] = we_i && pin_hit && pin_idx == IDX_W'(p) &&  c2_sel;

    gpio_pin_cfg u_cfg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_c1_i(wr_c1[p]),
      .wr_c2_i(wr_c2[p]),
      .wdata_i(wdata_i),
      .cfg_o  (cfg[p]),
      .oe_o   (pad_oe_o[p])
    );

    assign sense_lvl[p]        = sync_lvl[p] & ~cfg[p].sense_off;
    assign pad_out_o[p]        = cfg[p].out_lvl;
    assign pad_ie_o[p]         = ~cfg[p].sense_off;
    assign pad_pull_o[2*p +: 2] = cfg[p].pull;
    assign trig_level_o[p]     = cfg[p].trig_lvl;
    assign trig_inv_o[p]       = cfg[p].trig_inv;

    if (SLOT >= 0) begin : g_rt
      assign route_o[p] = route_bits[SLOT];
    end else begin : g_nort
      assign route_o[p] = 1'b0;
    end

    assert_sense_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_c2[p] && wdata_i[2]) |=> !sense_o[p]);
  end

  assign sense_o  = sense_lvl;
  assign int_en_o = en & own;

  gpio_bitmaps #(.NUM_PINS(NUM_PINS)) u_bm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (!in_pin),
    .we_i        (we_i),
    .grp_i       (addr_i[7:4]),
    .widx_i      (addr_i[3:2]),
    .wdata_i     (wdata_i),
    .irq_event_i (irq_event_i),
    .own_o       (own),
    .en_o        (en),
    .route_bits_o(route_bits),
    .gsel_o      (irq_line_sel_o),
    .hit_o       (bm_hit),
    .rd_o        (bm_rd)
  );

  always_comb begin
    sel_cfg   = PIN_CFG_RST;
    sel_sense = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pin_idx == IDX_W'(p)) begin
        sel_cfg   = cfg[p];
        sel_sense = sense_lvl[p];
      end
    end
  end

  assign pin_word = c2_sel ? {29'b0, sel_cfg.sense_off, sel_cfg.pull}
                           : {sel_cfg.out_lvl, sel_sense, 25'b0, sel_cfg.trig_lvl,
                              sel_cfg.trig_inv, sel_cfg.dir_in, sel_cfg.use_sel};
  assign rd_word  = pin_hit ? pin_word : bm_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;

  logic unused_addr;
  assign unused_addr = ^{addr_i[1:0], pin_off[1:0]};

  assert_unmapped_reads_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !pin_hit && !bm_hit) |=> rdata_o == 32'h0);

  assert_rdata_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

endmodule

// File: tb/gpio_pad_regbank_tb.sv
module gpio_pad_regbank_tb_top;

  localparam int NP = 95;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic            we = 1'b0, re = 1'b0;
  logic [31:0]     rdata;
  logic [NP-1:0]   pad_in = '0, evt = '0;
  logic [NP-1:0]   pad_out, pad_oe, pad_ie, sense, trig_l, trig_v, route, int_en;
  logic [2*NP-1:0] pull;
  logic            gsel;

  int nvec = 0, nerr = 0;
  bit cmp_en = 0;

  always #2.5 clk = ~clk;

  gpio_pad_regbank #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_ie_o(pad_ie), .pad_pull_o(pull), .sense_o(sense), .trig_level_o(trig_l),
    .trig_inv_o(trig_v), .route_o(route), .int_en_o(int_en), .irq_event_i(evt),
    .irq_line_sel_o(gsel)
  );

  // reference model state
  bit       m_out[NP], m_trg[NP], m_inv[NP], m_dir[NP], m_dis[NP];
  bit [1:0] m_use[NP], m_pul[NP];
  bit       m_own[NP], m_en[NP], m_stat[NP], m_s1[NP], m_s2[NP];
  bit [15:0] m_route;
  bit       m_gsel;
  logic [31:0] m_rd;
  int       m_last_addr;

  function automatic int rslot(int p);
    if (p >= 8 && p <= 10)  return p - 8;
    if (p == 13 || p == 14) return p - 10;
    if (p >= 45 && p <= 55) return p - 40;
    return -1;
  endfunction

  function automatic string tag_of(int a);
    int g, w;
    if (a >= 256) begin
      if ((a - 256) / 8 < NP) return (a % 8 == 0) ? "R4" : "R5";
      return "R12";
    end
    if (a == 'h7C) return "R11";
    g = a / 16; w = (a % 16) / 4;
    if (g == 1) return (w == 0) ? "R8" : "R12";
    if (w >= 3) return "R12";
    if (g == 0 || g == 9) return "R3";
    if (g == 8) return "R9";
    return "R12";
  endfunction

  function automatic logic [31:0] model_read(int a);
    logic [31:0] v;
    int g, w, p;
    v = '0;
    a = a - (a % 4);
    if (a >= 256) begin
      p = (a - 256) / 8;
      if (p < NP) begin
        if (a % 8 == 0) begin
          v[31] = m_out[p]; v[30] = m_s2[p] && !m_dis[p];
          v[4] = m_trg[p]; v[3] = m_inv[p]; v[2] = m_dir[p]; v[1:0] = m_use[p];
        end else begin
          v[2] = m_dis[p]; v[1:0] = m_pul[p];
        end
      end
      return v;
    end
    if (a == 'h7C) begin v[0] = m_gsel; return v; end
    g = a / 16; w = (a % 16) / 4;
    if (g == 1) begin
      if (w == 0) v[15:0] = m_route;
      return v;
    end
    if (w >= 3) return v;
    for (int b = 0; b < 32; b++) begin
      p = w * 32 + b;
      if (p < NP) begin
        if (g == 0) v[b] = m_own[p];
        if (g == 9) v[b] = m_en[p];
        if (g == 8) v[b] = m_stat[p];
      end
    end
    return v;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_out[p] = 0; m_trg[p] = 0; m_inv[p] = 0; m_dir[p] = 1; m_use[p] = 2'd1;
      m_dis[p] = 0; m_pul[p] = 0; m_own[p] = 0; m_en[p] = 0; m_stat[p] = 0;
      m_s1[p] = 0; m_s2[p] = 0;
    end
    m_route = 0; m_gsel = 0; m_rd = 0; m_last_addr = 0;
  endtask

  task automatic model_step();
    int a, g, w, p;
    bit clr;
    a = int'(addr); a = a - (a % 4);
    if (re) begin m_rd = model_read(a); m_last_addr = a; end
    g = a / 16; w = (a % 16) / 4;
    for (int q = 0; q < NP; q++) begin
      clr = we && a < 256 && g == 8 && w < 3 && q / 32 == w && wdata[q % 32];
      m_stat[q] = (m_stat[q] && !clr) || (evt[q] && m_own[q]);
    end
    if (we) begin
      if (a >= 256) begin
        p = (a - 256) / 8;
        if (p < NP) begin
          if (a % 8 == 0) begin
            m_out[p] = wdata[31]; m_trg[p] = wdata[4]; m_inv[p] = wdata[3];
            m_dir[p] = wdata[2]; m_use[p] = wdata[1:0];
          end else begin
            m_dis[p] = wdata[2]; m_pul[p] = wdata[1:0];
          end
        end
      end else if (a == 'h7C) begin
        m_gsel = wdata[0];
      end else if (g == 1 && w == 0) begin
        m_route = wdata[15:0];
      end else if ((g == 0 || g == 9) && w < 3) begin
        for (int b = 0; b < 32; b++) begin
          p = w * 32 + b;
          if (p < NP) begin
            if (g == 0) m_own[p] = wdata[b];
            else        m_en[p]  = wdata[b];
          end
        end
      end
    end
    for (int q = 0; q < NP; q++) begin m_s2[q] = m_s1[q]; m_s1[q] = pad_in[q]; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      logic [NP-1:0] e_out, e_oe, e_ie, e_sn, e_tl, e_ti, e_rt, e_ie2;
      logic [2*NP-1:0] e_pl;
      for (int p = 0; p < NP; p++) begin
        e_out[p] = m_out[p];
        e_oe[p]  = (m_use[p] == 2'd1) && !m_dir[p];
        e_ie[p]  = !m_dis[p];
        e_sn[p]  = m_s2[p] && !m_dis[p];
        e_tl[p]  = m_trg[p];
        e_ti[p]  = m_inv[p];
        e_rt[p]  = (rslot(p) >= 0) ? m_route[rslot(p)] : 1'b0;
        e_ie2[p] = m_en[p] && m_own[p];
        e_pl[2*p +: 2] = m_pul[p];
      end
      chk({"R2 ", tag_of(m_last_addr)}, "rdata_o", rdata, m_rd);
      chk("R6", "pad_out_o", pad_out, e_out);
      chk("R6", "pad_oe_o", pad_oe, e_oe);
      chk("R7", "pad_ie_o", pad_ie, e_ie);
      chk("R7", "sense_o", sense, e_sn);
      chk("R5", "pad_pull_o", pull, e_pl);
      chk("R4", "trig_level_o", trig_l, e_tl);
      chk("R4", "trig_inv_o", trig_v, e_ti);
      chk("R8", "route_o", route, e_rt);
      chk("R10", "int_en_o", int_en, e_ie2);
      chk("R11", "irq_line_sel_o", gsel, m_gsel);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; we = 1'b1; re = 1'b0;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    @(negedge clk); addr = AW'(a); re = 1'b1; we = 1'b0;
    @(negedge clk); re = 1'b0;
    chk(tag, $sformatf("read 0x%0h", a), rdata, exp);
  endtask

  task automatic pulse_evt(int p);
    @(negedge clk); evt[p] = 1'b1;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; cmp_en = 1;

    // R1 reset values
    chk("R1", "pad_oe_o", pad_oe, '0);
    chk("R1", "pad_ie_o", pad_ie, {NP{1'b1}});
    rd_chk('h100, 32'h0000_0005, "R1");
    rd_chk('h104, 32'h0, "R1");
    rd_chk('h3F0, 32'h0000_0005, "R1");
    rd_chk('h00, 32'h0, "R1");
    rd_chk('h10, 32'h0, "R1");
    rd_chk('h7C, 32'h0, "R1");

    // R4 field layout
    wr('h290, 32'hFFFF_FFFF);
    rd_chk('h290, 32'h8000_001F, "R4");
    chk("R4", "trig_level_o[50]", trig_l[50], 1'b1);
    chk("R4", "trig_inv_o[50]", trig_v[50], 1'b1);
    // R6 output enable / level
    chk("R6", "pad_oe_o[50] use=3", pad_oe[50], 1'b0);
    wr('h290, 32'h0000_0001);
    chk("R6", "pad_oe_o[50] gpio out", pad_oe[50], 1'b1);
    chk("R6", "pad_out_o[50]", pad_out[50], 1'b0);
    wr('h290, 32'h8000_0001);
    chk("R6", "pad_out_o[50] high", pad_out[50], 1'b1);
    wr('h290, 32'h8000_0000);
    chk("R6", "pad_oe_o[50] native", pad_oe[50], 1'b0);

    // R2 read latency and hold
    rd_chk('h290, 32'h8000_0000, "R2");
    wr('h290, 32'h0);
    chk("R2", "rdata_o hold", rdata, 32'h8000_0000);

    // R5 second word
    wr('h3F4, 32'h0000_0006);
    rd_chk('h3F4, 32'h0000_0006, "R5");
    chk("R5", "pad_pull_o[94]", pull[189:188], 2'd2);
    chk("R7", "pad_ie_o[94] off", pad_ie[94], 1'b0);
    wr('h3F4, 32'h0000_0001);
    chk("R5", "pad_pull_o[94] down", pull[189:188], 2'd1);

    // R7 synchroniser and sense gating
    @(negedge clk); pad_in[3] = 1'b1;
    @(negedge clk);
    chk("R7", "sense_o[3] after 1 edge", sense[3], 1'b0);
    @(negedge clk);
    chk("R7", "sense_o[3] after 2 edges", sense[3], 1'b1);
    rd_chk('h118, 32'h4000_0005, "R7");
    wr('h11C, 32'h0000_0004);
    chk("R7", "sense_o[3] disabled", sense[3], 1'b0);
    rd_chk('h118, 32'h0000_0005, "R7");

    // R8 routing
    wr('h10, 32'hFFFF_FFFF);
    rd_chk('h10, 32'h0000_FFFF, "R8");
    chk("R8", "route_o[8]", route[8], 1'b1);
    chk("R8", "route_o[55]", route[55], 1'b1);
    chk("R8", "route_o[11]", route[11], 1'b0);
    chk("R8", "route_o[56]", route[56], 1'b0);
    rd_chk('h14, 32'h0, "R8");

    // R3 / R10 ownership and enable
    wr('h08, 32'hFFFF_FFFF);
    rd_chk('h08, 32'h7FFF_FFFF, "R3");
    wr('h98, 32'hFFFF_FFFF);
    rd_chk('h98, 32'h7FFF_FFFF, "R3");
    chk("R10", "int_en_o[94]", int_en[94], 1'b1);
    wr('h90, 32'h0000_0001);
    chk("R10", "int_en_o[0] unowned", int_en[0], 1'b0);

    // R9 status
    pulse_evt(0);
    rd_chk('h80, 32'h0, "R9");
    pulse_evt(70);
    rd_chk('h88, 32'h0000_0040, "R9");
    wr('h88, 32'h0000_0040);
    rd_chk('h88, 32'h0, "R9");
    @(negedge clk); addr = AW'('h88); wdata = 32'h40; we = 1'b1; evt[70] = 1'b1;
    @(negedge clk); we = 1'b0; evt = '0;
    rd_chk('h88, 32'h0000_0040, "R9");

    // R11 global control
    wr('h7C, 32'hFFFF_FFFF);
    chk("R11", "irq_line_sel_o", gsel, 1'b1);
    rd_chk('h7C, 32'h0000_0001, "R11");

    // R12 unmapped space
    wr('h3F8, 32'hFFFF_FFFF);
    rd_chk('h3F8, 32'h0, "R12");
    rd_chk('h0C, 32'h0, "R12");
    rd_chk('h8C, 32'h0, "R12");
    rd_chk('h400, 32'h0, "R12");
    wr('h0C, 32'hFFFF_FFFF);
    rd_chk('h00, 32'h0, "R12");

    // random traffic, checked by the model every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      addr  = ($urandom % 3 == 0) ? AW'(($urandom % 64) * 4) : AW'(($urandom % 262) * 4);
      wdata = $urandom;
      we    = ($urandom % 3 == 0);
      re    = ($urandom % 2 == 0);
      for (int p = 0; p < NP; p++) evt[p] = ($urandom % 8 == 0);
      if ($urandom % 4 == 0) pad_in[$urandom % NP] ^= 1'b1;
    end
    @(negedge clk); we = 1'b0; re = 1'b0; evt = '0;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule